// File: doc/BRIEF.md
# Fly-by Four-Channel DMA Controller

This block moves blocks of bytes between I/O devices and memory without ever holding the data. It drives only the memory address and a pair of strobes. The data goes straight from the port to memory, or from memory to the port. Software first programs three things for each channel through a small write port: a start address, a byte count and a direction. After that, the device on that channel starts a block by raising its request line.

When a request arrives, the controller asks the processor for the bus with a hold request and waits for hold acknowledge. Once the bus is granted, it raises the device's acknowledge line and runs one two-cycle step per byte. The first cycle of each step drives the address and the strobe pair, and the second cycle advances the address and the count. When the count reaches zero, the controller releases the bus and pulses a per-channel completion interrupt.

Only one channel is served at a time. Requests that are pending together are resolved by fixed priority. A running block is never cut short by another request.

Top module: `flyby_dma`

## Requirements
- R1: After reset, holdReq, dmaAck, memRd, memWr, ioRd, ioWr and doneIrq are all low.
- R2: A request on a channel whose count register is nonzero raises holdReq one cycle later. A request on a channel whose count is zero, including a channel whose block has finished, does nothing and holdReq stays low.
- R3: While holdAck is low after holdReq has risen, dmaAck and all four strobes stay low.
- R4: holdReq stays high from the first request until the block's last step. It falls in the same cycle that the completion pulse appears.
- R5: During a block, dmaAck is one-hot on the serviced channel in every strobe cycle, and it is low once the block completes.
- R6: Direction value 1 asserts memRd with ioWr, and direction value 0 asserts ioRd with memWr. The other pair stays low. Strobes are high for one cycle of each two-cycle step and never in two consecutive cycles.
- R7: The first strobe carries the programmed start address. Each later strobe carries the previous address plus one, wrapping at the address width. The number of strobes equals the programmed count.
- R8: In the cycle after the last step, doneIrq has exactly the serviced channel's bit set, and it is low again one cycle later.
- R9: When several armed channels request together, the lowest-numbered one is served first and the others follow afterwards.
- R10: A request that arrives during a block does not interrupt it. Every strobe of the block belongs to the channel that started it.
- R11: Register writes use cfgSel 0 for the address, 1 for the count and 2 for the direction (cfgData bit 0). A write aimed at the channel currently being served is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write enable |
| cfgChan | input | 2 | Channel addressed by the write |
| cfgSel | input | 2 | Register select: 0 address, 1 count, 2 direction |
| cfgData | input | ADDR_W | Write data |
| dmaReq | input | NUM_CH | Per-channel device request |
| dmaAck | output | NUM_CH | Per-channel device acknowledge |
| holdReq | output | 1 | Bus request to processor |
| holdAck | input | 1 | Bus grant from processor |
| memAddr | output | ADDR_W | Memory address, valid while a strobe is high |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| doneIrq | output | NUM_CH | One-cycle completion pulse per channel |

## Verification
The assertions assume two things about the processor. First, once it grants the bus with holdAck, it keeps holdAck high until holdReq falls. Second, it never raises holdAck while holdReq is low. The bench drives holdAck only after it has seen holdReq high, and it lowers holdAck only in the cycle where the completion pulse is observed, so both conditions hold throughout. Devices lower their request after their acknowledge appears. Requests arriving during a block are deliberately left high to exercise the no-preemption rule.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CH_IDX_W = 2;
  localparam int MAX_CH   = 1 << CH_IDX_W;

  typedef struct packed {
    logic                step;  // advance address and count of chan
    logic [CH_IDX_W-1:0] chan;  // channel under service
  } dp_ctl_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_WAIT   = 2'd1,
    S_STROBE = 2'd2,
    S_GAP    = 2'd3
  } dma_state_e;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CH_IDX_W-1:0] cfgChan,
  input  logic [1:0]          cfgSel,
  input  logic [ADDR_W-1:0]   cfgData,
  input  logic                busy,
  input  dp_ctl_t             ctl,
  output logic [NUM_CH-1:0]   armed,
  output logic [ADDR_W-1:0]   curAddr,
  output logic                curLast,
  output logic                curDir
);
  logic [ADDR_W-1:0] addrQ [NUM_CH];
  logic [CNT_W-1:0]  cntQ  [NUM_CH];
  logic [NUM_CH-1:0] dirQ;

  logic wrOk;
  assign wrOk = cfgWe && !(busy && cfgChan == ctl.chan);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[i] <= '0;
        cntQ[i]  <= '0;
        dirQ[i]  <= 1'b0;
      end else if (ctl.step && ctl.chan == CH_IDX_W'(i)) begin
        addrQ[i] <= addrQ[i] + 1'b1;
        cntQ[i]  <= cntQ[i] - 1'b1;
      end else if (wrOk && cfgChan == CH_IDX_W'(i)) begin
        case (cfgSel)
          2'd0:    addrQ[i] <= cfgData;
          2'd1:    cntQ[i]  <= cfgData[CNT_W-1:0];
          2'd2:    dirQ[i]  <= cfgData[0];
          default: ;
        endcase
      end
    end
    assign armed[i] = cntQ[i] != '0;
  end

  assign curAddr = addrQ[ctl.chan];
  assign curLast = cntQ[ctl.chan] == CNT_W'(1);
  assign curDir  = dirQ[ctl.chan];

  // R7: each step advances the served channel's address by exactly one
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> addrQ[$past(ctl.chan)] == $past(addrQ[ctl.chan]) + 1'b1);

  // R11: served channel's count only moves by the step, never by a write
  p_cnt_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> cntQ[$past(ctl.chan)] == $past(cntQ[ctl.chan]) - 1'b1);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dmaReq,
  input  logic [NUM_CH-1:0] armed,
  input  logic              holdAck,
  input  logic              curLast,
  input  logic              curDir,
  output dp_ctl_t           ctl,
  output logic              busy,
  output logic              holdReq,
  output logic [NUM_CH-1:0] dmaAck,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic [NUM_CH-1:0] doneIrq
);
  dma_state_e          stateQ, stateD;
  logic [CH_IDX_W-1:0] chanQ, pickIdx;
  logic [NUM_CH-1:0]   cand;

  assign cand = dmaReq & armed;

  // fixed priority: lowest index wins (last assignment in descending loop)
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (cand[i]) pickIdx = CH_IDX_W'(i);
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      S_IDLE:   if (|cand) stateD = S_WAIT;
      S_WAIT:   if (holdAck) stateD = S_STROBE;
      S_STROBE: stateD = S_GAP;
      S_GAP:    stateD = curLast ? S_IDLE : S_STROBE;
      default:  stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      chanQ   <= '0;
      doneIrq <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_IDLE && |cand) chanQ <= pickIdx;
      for (int i = 0; i < NUM_CH; i++)
        doneIrq[i] <= stateQ == S_GAP && curLast && chanQ == CH_IDX_W'(i);
    end
  end

  logic inBlock, strobeOn;
  assign inBlock  = stateQ == S_STROBE || stateQ == S_GAP;
  assign strobeOn = stateQ == S_STROBE;

  assign busy     = stateQ != S_IDLE;
  assign holdReq  = busy;
  assign ctl.step = stateQ == S_GAP;
  assign ctl.chan = chanQ;
  assign memRd    = strobeOn &&  curDir;
  assign ioWr     = strobeOn &&  curDir;
  assign ioRd     = strobeOn && !curDir;
  assign memWr    = strobeOn && !curDir;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ack
    assign dmaAck[i] = inBlock && chanQ == CH_IDX_W'(i);
  end

  // R5: at most one acknowledge at a time
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dmaAck));
  // R4: bus is released only together with a completion pulse
  p_hold_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdReq) |-> |doneIrq);
  // R3: no bus activity without grant
  p_no_strobe_ungranted_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || ioRd) |-> holdAck && |dmaAck);
  // R6: strobes come in the matching pair and last one cycle
  p_strobe_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> ioWr && !memWr && !ioRd);
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || ioRd) |=> !(memRd || ioRd));
  // R10: served channel stays fixed during a block
  p_no_preempt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inBlock && $past(inBlock)) |-> $stable(dmaAck));
  // R8: completion pulse lasts one cycle
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    |doneIrq |=> !(|doneIrq));
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import dma_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CH_IDX_W-1:0] cfgChan,
  input  logic [1:0]          cfgSel,
  input  logic [ADDR_W-1:0]   cfgData,
  input  logic [NUM_CH-1:0]   dmaReq,
  output logic [NUM_CH-1:0]   dmaAck,
  output logic                holdReq,
  input  logic                holdAck,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRd,
  output logic                memWr,
  output logic                ioRd,
  output logic                ioWr,
  output logic [NUM_CH-1:0]   doneIrq
);
  initial begin
    if (NUM_CH > MAX_CH || CNT_W > ADDR_W)
      $error("flyby_dma: unsupported parameter combination");
  end

  dp_ctl_t           ctl;
  logic              busy, curLast, curDir;
  logic [NUM_CH-1:0] armed;

  dma_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk, .rstN, .dmaReq, .armed, .holdAck, .curLast, .curDir,
    .ctl, .busy, .holdReq, .dmaAck, .memRd, .memWr, .ioRd, .ioWr, .doneIrq
  );

  dma_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .cfgWe, .cfgChan, .cfgSel, .cfgData, .busy, .ctl,
    .armed, .curAddr(memAddr), .curLast, .curDir
  );
endmodule

// File: tb/flyby_dma_bench.sv
module flyby_dma_bench;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgChan = '0;
  logic [1:0]        cfgSel = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic [NUM_CH-1:0] dmaReq = '0;
  logic [NUM_CH-1:0] dmaAck;
  logic              holdReq;
  logic              holdAck = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRd, memWr, ioRd, ioWr;
  logic [NUM_CH-1:0] doneIrq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flyby_dma u_flyby_dma (
    .clk, .rstN, .cfgWe, .cfgChan, .cfgSel, .cfgData, .dmaReq, .dmaAck,
    .holdReq, .holdAck, .memAddr, .memRd, .memWr, .ioRd, .ioWr, .doneIrq
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic prog(input int ch, input int sel, input int data);
    cfgWe = 1'b1; cfgChan = 2'(ch); cfgSel = 2'(sel); cfgData = ADDR_W'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setup(input int ch, input int addr, input int cnt, input bit dir);
    prog(ch, 0, addr);
    prog(ch, 1, cnt);
    prog(ch, 2, int'(dir));
  endtask

  // run one block; called at a negedge
  task automatic runBlock(input int ch, input int reqMask, input int addr,
                          input int cnt, input bit dir, input int grantDelay,
                          input bit midWrite, input int lateMask);
    int k = 0;
    bit done = 0;
    bit prevStb = 0;
    int cyc = 0;
    logic [3:0] expStb = dir ? 4'b1001 : 4'b0110;
    dmaReq |= NUM_CH'(reqMask);
    @(negedge clk);
    check(holdReq == 1'b1, "R2", "holdReq after request", int'(holdReq), 1);
    for (int d = 0; d < grantDelay; d++) begin
      check(dmaAck == '0 && {memRd, memWr, ioRd, ioWr} == 4'b0, "R3",
            "activity before grant", int'({dmaAck, memRd, memWr, ioRd, ioWr}), 0);
      @(negedge clk);
    end
    holdAck = 1'b1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cfgWe = 1'b0;
      cyc++;
      if (doneIrq != '0) begin
        check(doneIrq == NUM_CH'(1 << ch), "R8", "completion pulse", int'(doneIrq), 1 << ch);
        check(holdReq == 1'b0, "R4", "holdReq at completion", int'(holdReq), 0);
        check(dmaAck == '0, "R5", "ack after completion", int'(dmaAck), 0);
        done = 1;
      end else begin
        logic [3:0] stb = {memRd, memWr, ioRd, ioWr};
        if (!holdReq) check(0, "R4", "holdReq dropped mid-block", 0, 1);
        if (stb != 4'b0) begin
          if (prevStb) check(0, "R6", "strobe in consecutive cycles", 1, 0);
          check(stb == expStb, "R6", "strobe pair", int'(stb), int'(expStb));
          check(dmaAck == NUM_CH'(1 << ch), "R10", "ack channel at strobe", int'(dmaAck), 1 << ch);
          check(memAddr == ADDR_W'(addr + k), "R7", "strobe address", int'(memAddr),
                int'(ADDR_W'(addr + k)));
          k++;
          if (k == 1) begin
            dmaReq[ch] = 1'b0;
            dmaReq |= NUM_CH'(lateMask);
            if (midWrite) begin
              cfgWe = 1'b1; cfgChan = 2'(ch); cfgSel = 2'd1; cfgData = 16'd5;
            end
          end
        end
        prevStb = stb != 4'b0;
      end
    end
    check(done, "R8", "block completed within watchdog", int'(done), 1);
    check(k == cnt, "R7", "number of strobes", k, cnt);
    holdAck = 1'b0;
    @(negedge clk);
    check(doneIrq == '0, "R8", "pulse lasts one cycle", int'(doneIrq), 0);
  endtask

  task automatic expectIgnored(input int ch);
    dmaReq[ch] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (holdReq) check(0, "R2", "holdReq for disarmed channel", 1, 0);
    end
    check(holdReq == 1'b0, "R2", "disarmed request ignored", int'(holdReq), 0);
    dmaReq[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset;
    check(holdReq == 0 && dmaAck == 0 && doneIrq == 0 &&
          {memRd, memWr, ioRd, ioWr} == 0, "R1", "outputs after reset",
          int'({holdReq, dmaAck, doneIrq, memRd, memWr, ioRd, ioWr}), 0);
  endtask

  task automatic testMemToIo;
    setup(0, 16'h1000, 3, 1'b1);
    runBlock(0, 1 << 0, 16'h1000, 3, 1'b1, 3, 1'b0, 0);
  endtask

  task automatic testIoToMemWrap;
    setup(2, 16'hFFFE, 4, 1'b0);
    runBlock(2, 1 << 2, 16'hFFFE, 4, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic testPriority;
    setup(1, 16'h0100, 2, 1'b1);
    setup(3, 16'h0300, 2, 1'b0);
    // R9: both request at once, channel 1 goes first
    runBlock(1, (1 << 1) | (1 << 3), 16'h0100, 2, 1'b1, 1, 1'b0, 0);
    runBlock(3, 0, 16'h0300, 2, 1'b0, 1, 1'b0, 0);
  endtask

  task automatic testNoPreemptAndLock;
    setup(3, 16'h3000, 4, 1'b1);
    setup(0, 16'h0040, 2, 1'b0);
    // R10 late request on 0; R11 count write to active channel 3
    runBlock(3, 1 << 3, 16'h3000, 4, 1'b1, 2, 1'b1, 1 << 0);
    runBlock(0, 0, 16'h0040, 2, 1'b0, 0, 1'b0, 0);
    expectIgnored(3);  // R11: write ignored, count still zero
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    expectIgnored(1);  // R2: never programmed
    testMemToIo();
    expectIgnored(0);  // R2: exhausted
    testIoToMemWrap();
    testPriority();
    testNoPreemptAndLock();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule